// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode

This block reads instructions over a 16-bit instruction bus and turns each one into decoded fields for an execute stage. It requests the halfword at the current program counter. From the 6-bit opcode in that halfword it decides whether the instruction is two or four bytes long. For four-byte instructions it requests a second halfword at the next address and appends it. The assembled 32-bit word is then split into a format number, register indices, an extended immediate or displacement, a condition code, a sub-opcode and an illegal flag. The byte size is reported too, so the logic outside can advance the program counter.

The memory side is a request/acknowledge port: a request stays high until an acknowledge arrives in the same cycle as the read data. The execute side is a valid/ready pair. The decoded result stays on the outputs until it is accepted, and the next fetch starts in the cycle after acceptance. A flush input abandons any fetch in progress and returns the block to requesting a first halfword at the current `pc_in`.

Top module: `insn_fetch_decode`

## Requirements
- R1: Out of reset the block requests a first halfword (`mem_req` high) at address `pc_in`, and `dec_valid` is low.
- R2: The first halfword lands in bits 31:16 of `dec_word`, and the opcode is `dec_word[31:26]`. An instruction of format 0, 1, 2 or 3 completes after that single fetch with `dec_size` = 2 and `dec_word[15:0]` = 0.
- R3: An instruction of format 4 to 7 causes a second fetch at `pc_in`+2. That halfword lands in `dec_word[15:0]` and `dec_size` = 4.
- R4: Opcode to format mapping: 0x00-0x0F are format 1. 0x10-0x1F are format 2, except 0x1B. 0x20-0x27 are format 3. 0x2A-0x2B are format 4. 0x28, 0x29 and 0x2C-0x2F are format 5. 0x30-0x3F are format 6, except 0x32, 0x36 and 0x3E. 0x3E is format 7. Opcodes 0x1B, 0x32 and 0x36 give format 0 with `dec_illegal` set.
- R5: `dec_reg2` = word bits 25:21 in formats 1, 2, 5, 6 and 7. `dec_reg1` = word bits 20:16 in formats 1, 5, 6 and 7. In every other case each is 0.
- R6: In format 2, `dec_imm` is word bits 20:16, sign-extended for opcodes 0x10, 0x11 and 0x13 and zero-extended otherwise. For opcode 0x12, `dec_cond` = word bits 19:16.
- R7: For format 3, `dec_opcode` reads 0x20, `dec_cond` = word bits 28:25, and `dec_imm` is word bits 24:16 sign-extended.
- R8: For format 4, `dec_imm` is word bits 25:0 sign-extended. For format 6, `dec_imm` is word bits 15:0 sign-extended.
- R9: For format 5, `dec_imm` is word bits 15:0, sign-extended for opcodes 0x28 and 0x29 and zero-extended for 0x2C-0x2F.
- R10: For format 7, `dec_subop` = word bits 15:10, and values 16 or above set `dec_illegal`. For opcode 0x1F, `dec_subop` = word bits 20:16, and values 16 or above set `dec_illegal`. Fields that a format does not define read 0.
- R11: While `dec_valid` is high and `dec_ready` is low, every output stays unchanged. After acceptance, `dec_valid` drops and a new first fetch is requested in the next cycle.
- R12: A flush drops `dec_valid` and abandons any pending second fetch. In the next cycle the block requests a first halfword at `pc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Abandon the current instruction and restart at `pc_in` |
| pc_in | input | AW | Address of the next instruction; held steady while the first fetch is requested |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | AW | Halfword fetch address |
| mem_ack | input | 1 | Fetch done; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 16 | Fetched halfword |
| dec_valid | output | 1 | Decoded instruction available |
| dec_ready | input | 1 | Execute stage accepts the instruction |
| dec_word | output | 32 | Assembled instruction word |
| dec_opcode | output | 6 | Opcode (branches read 0x20) |
| dec_format | output | 3 | Format 1-7, 0 for an illegal opcode |
| dec_size | output | 3 | Instruction length in bytes (2 or 4) |
| dec_reg1 | output | 5 | First register index |
| dec_reg2 | output | 5 | Second register index |
| dec_imm | output | 32 | Extended immediate or displacement |
| dec_cond | output | 4 | Condition code |
| dec_subop | output | 6 | Sub-opcode |
| dec_illegal | output | 1 | Instruction is illegal |

## Verification
On every cycle, assertions check the handshake rules. Outputs must hold while an offer waits. Request and valid must never be high together. The second fetch must go exactly two bytes above the first, and a flush must always lead to a fresh first request. They also check that the size is legal and that an out-of-range sub-opcode is flagged. The field layouts can only be shown by the bench's sweeps. These cover all 64 opcodes, all 64 format-7 sub-opcodes and all 32 bit-string selectors, with expected fields computed arithmetically. A flush in the middle of an instruction and variable acceptance delays are also shown only by the scenarios.

// File: rtl/insn_fetch_decode.sv
module insn_fetch_decode #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] pc_in,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [31:0]   dec_word,
  output logic [5:0]    dec_opcode,
  output logic [2:0]    dec_format,
  output logic [2:0]    dec_size,
  output logic [4:0]    dec_reg1,
  output logic [4:0]    dec_reg2,
  output logic [31:0]   dec_imm,
  output logic [3:0]    dec_cond,
  output logic [5:0]    dec_subop,
  output logic          dec_illegal
);

  typedef enum logic [1:0] {ST_FIRST, ST_SECOND, ST_HOLD} state_t;

  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  function automatic logic [2:0] fmt_of(input logic [5:0] op);
    if (op < 6'h10)                    return 3'd1;
    else if (op < 6'h20)               return (op == 6'h1B) ? 3'd0 : 3'd2;
    else if (op < 6'h28)               return 3'd3;
    else if (op == 6'h2A || op == 6'h2B) return 3'd4;
    else if (op < 6'h30)               return 3'd5;
    else if (op == 6'h32 || op == 6'h36) return 3'd0;
    else if (op == 6'h3E)              return 3'd7;
    else                               return 3'd6;
  endfunction

  state_t        state;
  logic [31:0]   word;
  logic [AW-1:0] base;
  logic [5:0]    op;
  logic [2:0]    fmt;
  logic          first_long;

  assign first_long = fmt_of(mem_rdata[15:10]) >= 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FIRST;
      word  <= '0;
      base  <= '0;
    end else if (flush) begin
      state <= ST_FIRST;
    end else begin
      case (state)
        ST_FIRST: if (mem_ack) begin
          word  <= {mem_rdata, 16'h0000};
          base  <= pc_in;
          state <= first_long ? ST_SECOND : ST_HOLD;
        end
        ST_SECOND: if (mem_ack) begin
          word[15:0] <= mem_rdata;
          state      <= ST_HOLD;
        end
        default: if (dec_ready) state <= ST_FIRST;
      endcase
    end
  end

  assign mem_req   = (state != ST_HOLD);
  assign mem_addr  = (state == ST_SECOND) ? base + HALF_STEP : pc_in;
  assign dec_valid = (state == ST_HOLD);
  assign dec_word  = word;

  assign op         = word[31:26];
  assign fmt        = fmt_of(op);
  assign dec_format = fmt;
  assign dec_size   = (fmt >= 3'd4) ? 3'd4 : 3'd2;

  always_comb begin
    dec_opcode  = op;
    dec_reg1    = '0;
    dec_reg2    = '0;
    dec_imm     = '0;
    dec_cond    = '0;
    dec_subop   = '0;
    dec_illegal = 1'b0;
    case (fmt)
      3'd1: begin
        dec_reg2 = word[25:21];
        dec_reg1 = word[20:16];
      end
      3'd2: begin
        dec_reg2 = word[25:21];
        if (op == 6'h10 || op == 6'h11 || op == 6'h13)
          dec_imm = {{27{word[20]}}, word[20:16]};
        else
          dec_imm = {27'd0, word[20:16]};
        if (op == 6'h12) dec_cond = word[19:16];
        if (op == 6'h1F) begin
          dec_subop   = {1'b0, word[20:16]};
          dec_illegal = word[20];
        end
      end
      3'd3: begin
        dec_opcode = 6'h20;
        dec_cond   = word[28:25];
        dec_imm    = {{23{word[24]}}, word[24:16]};
      end
      3'd4: dec_imm = {{6{word[25]}}, word[25:0]};
      3'd5: begin
        dec_reg2 = word[25:21];
        dec_reg1 = word[20:16];
        if (op == 6'h28 || op == 6'h29)
          dec_imm = {{16{word[15]}}, word[15:0]};
        else
          dec_imm = {16'd0, word[15:0]};
      end
      3'd6: begin
        dec_reg2 = word[25:21];
        dec_reg1 = word[20:16];
        dec_imm  = {{16{word[15]}}, word[15:0]};
      end
      3'd7: begin
        dec_reg2    = word[25:21];
        dec_reg1    = word[20:16];
        dec_subop   = word[15:10];
        dec_illegal = word[15] | word[14];
      end
      default: dec_illegal = 1'b1;
    endcase
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !flush) |=> (dec_valid && $stable(dec_word) && $stable(dec_imm)));

  // R11
  req_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dec_valid));

  // R3
  second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !dec_valid && mem_ack && !flush && $stable(mem_addr) && first_long && state == ST_FIRST)
      |=> (flush || (mem_req && mem_addr == $past(mem_addr) + HALF_STEP)));

  // R12
  flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!dec_valid && mem_req));

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_size == 3'd2 || dec_size == 3'd4));

  // R10
  subop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_format == 3'd7 && dec_subop >= 6'd16) |-> dec_illegal);

endmodule

// File: tb/test_insn_fetch_decode.sv
module test_insn_fetch_decode;
  logic clk = 0, rst_n = 0, flush = 0, mem_ack = 0, dec_ready = 0;
  logic [31:0] pc_in = 32'h0000_1000;
  logic [15:0] mem_rdata = 16'h0;
  logic mem_req, dec_valid, dec_illegal;
  logic [31:0] mem_addr, dec_word, dec_imm;
  logic [5:0] dec_opcode, dec_subop;
  logic [2:0] dec_format, dec_size;
  logic [4:0] dec_reg1, dec_reg2;
  logic [3:0] dec_cond;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  insn_fetch_decode i_insn_fetch_decode (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pc_in(pc_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_word(dec_word),
    .dec_opcode(dec_opcode), .dec_format(dec_format), .dec_size(dec_size),
    .dec_reg1(dec_reg1), .dec_reg2(dec_reg2), .dec_imm(dec_imm), .dec_cond(dec_cond),
    .dec_subop(dec_subop), .dec_illegal(dec_illegal));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_fields(input logic [31:0] w,
      output logic [2:0] f, output logic [5:0] opc, output logic [4:0] r1, output logic [4:0] r2,
      output logic [31:0] imm, output logic [3:0] cnd, output logic [5:0] sub, output logic ill);
    int o = int'(w[31:26]);
    int v;
    opc = w[31:26]; r1 = 0; r2 = 0; imm = 0; cnd = 0; sub = 0; ill = 0;
    if (o == 27 || o == 50 || o == 54) f = 0;
    else if (o <= 15) f = 1;
    else if (o <= 31) f = 2;
    else if (o <= 39) f = 3;
    else if (o == 42 || o == 43) f = 4;
    else if (o <= 47) f = 5;
    else if (o == 62) f = 7;
    else f = 6;
    if (f inside {3'd1, 3'd2, 3'd5, 3'd6, 3'd7}) r2 = w[25:21];
    if (f inside {3'd1, 3'd5, 3'd6, 3'd7}) r1 = w[20:16];
    case (f)
      3'd0: ill = 1;
      3'd2: begin
        v = int'(w[20:16]);
        imm = (o == 16 || o == 17 || o == 19) && v >= 16 ? 32'(v - 32) : 32'(v);
        if (o == 18) cnd = 4'(v % 16);
        if (o == 31) begin sub = 6'(v); ill = v >= 16; end
      end
      3'd3: begin
        opc = 6'h20; cnd = w[28:25];
        v = int'(w[24:16]);
        imm = v >= 256 ? 32'(v - 512) : 32'(v);
      end
      3'd4: begin
        v = int'(w[25:0]);
        imm = v >= (1 << 25) ? 32'(v - (1 << 26)) : 32'(v);
      end
      3'd5: begin
        v = int'(w[15:0]);
        imm = (o == 40 || o == 41) && v >= 32768 ? 32'(v - 65536) : 32'(v);
      end
      3'd6: begin
        v = int'(w[15:0]);
        imm = v >= 32768 ? 32'(v - 65536) : 32'(v);
      end
      3'd7: begin sub = w[15:10]; ill = w[15:10] >= 16; end
      default: ;
    endcase
  endtask

  task automatic run_insn(input logic [31:0] pc, input logic [15:0] hi, input logic [15:0] lo,
                          input int ready_delay, input bit slow);
    int fetches = 0;
    bit got = 0;
    logic [31:0] w;
    logic [2:0] f; logic [5:0] opc, sub; logic [4:0] r1, r2; logic [31:0] imm; logic [3:0] cnd; logic ill;
    pc_in = pc;
    for (int c = 0; c < 30 && !got; c++) begin
      @(negedge clk);
      if (dec_valid) begin got = 1; mem_ack = 0; end
      else if (mem_req) begin
        if (slow && c % 2 == 0) mem_ack = 0;
        else begin
          chk(mem_addr == (fetches == 0 ? pc : pc + 2), fetches == 0 ? "R2 first addr" : "R3 second addr",
              mem_addr, fetches == 0 ? pc : pc + 2);
          mem_ack = 1; mem_rdata = fetches == 0 ? hi : lo;
          fetches++;
        end
      end else mem_ack = 0;
    end
    chk(got, "R11 valid timeout", 0, 1);
    if (!got) return;
    expect_fields({hi, 16'h0}, f, opc, r1, r2, imm, cnd, sub, ill);
    if (f >= 4) begin
      w = {hi, lo};
      expect_fields(w, f, opc, r1, r2, imm, cnd, sub, ill);
      chk(fetches == 2 && dec_size == 4, "R3 size/fetches", {dec_size, 8'(fetches)}, 32'h402);
    end else begin
      w = {hi, 16'h0};
      chk(fetches == 1 && dec_size == 2, "R2 size/fetches", {dec_size, 8'(fetches)}, 32'h201);
    end
    chk(dec_word == w, "R2/R3 word", dec_word, w);
    chk(dec_format == f, "R4 format", 32'(dec_format), 32'(f));
    chk(dec_illegal == ill, "R4/R10 illegal", 32'(dec_illegal), 32'(ill));
    chk(dec_opcode == opc, "R7 opcode", 32'(dec_opcode), 32'(opc));
    chk(dec_reg1 == r1 && dec_reg2 == r2, "R5 regs", {dec_reg2, dec_reg1}, {r2, r1});
    chk(dec_imm == imm, "R6/R7/R8/R9 imm", dec_imm, imm);
    chk(dec_cond == cnd, "R6/R7 cond", 32'(dec_cond), 32'(cnd));
    chk(dec_subop == sub, "R10 subop", 32'(dec_subop), 32'(sub));
    pc_in = pc + 32'h100;
    for (int d = 0; d < ready_delay; d++) begin
      @(negedge clk);
      chk(dec_valid && dec_word == w && dec_imm == imm, "R11 hold", dec_word, w);
    end
    dec_ready = 1;
    @(negedge clk);
    dec_ready = 0;
    chk(!dec_valid && mem_req && mem_addr == pc_in, "R11 next fetch", mem_addr, pc_in);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req && mem_addr == pc_in && !dec_valid, "R1 reset state", {mem_req, dec_valid}, 32'h2);
    for (int op = 0; op < 64; op++)
      for (int p = 0; p < 5; p++) begin
        logic [9:0] rest;
        rest = p == 0 ? 10'h000 : p == 1 ? 10'h3FF : p == 2 ? 10'h155 : p == 3 ? 10'h2AA : 10'(op * 37 + 5);
        run_insn(32'h2000 + 32'(op * 16), {6'(op), rest}, 16'((op * 977 + p * 4099) ^ (p << 15)), p % 3, p == 4);
      end
    // R10 sweep of format-7 sub-opcodes
    for (int s = 0; s < 64; s++)
      run_insn(32'h8000, {6'h3E, 10'(s * 11)}, {6'(s), 10'h1A5}, 0, 0);
    // R10 sweep of bit-string selector
    for (int s = 0; s < 32; s++)
      run_insn(32'h9000, {6'h1F, 5'(s * 3), 5'(s)}, 16'h0, 1, 0);
    // R12 flush during pending second fetch
    pc_in = 32'hA000;
    @(negedge clk);
    mem_ack = 1; mem_rdata = {6'h2B, 10'h3FF};
    @(negedge clk);
    mem_ack = 0;
    chk(mem_req && mem_addr == 32'hA002, "R3 second request", mem_addr, 32'hA002);
    flush = 1; pc_in = 32'hB000;
    @(negedge clk);
    flush = 0;
    chk(mem_req && !dec_valid && mem_addr == 32'hB000, "R12 flush restart", mem_addr, 32'hB000);
    run_insn(32'hB000, {6'h04, 10'h123}, 16'h0, 0, 0);
    // R12 flush while holding a decoded result
    pc_in = 32'hC000;
    @(negedge clk);
    mem_ack = 1; mem_rdata = {6'h01, 10'h0F0};
    @(negedge clk);
    mem_ack = 0;
    chk(dec_valid, "R12 valid before flush", 32'(dec_valid), 1);
    flush = 1;
    @(negedge clk);
    flush = 0;
    chk(!dec_valid && mem_req && mem_addr == 32'hC000, "R12 flush drops valid", {dec_valid, mem_req}, 32'h1);
    run_insn(32'hC000, {6'h2A, 10'h200}, 16'h8001, 2, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule